// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block links a parallel stereo sample interface to a three-wire serial audio bus whose bit clock and word clock come from outside. The bus lines are brought into the system clock domain by short synchronizer chains, and the block works on edge pulses taken from the synchronized bit clock. One bit-clock edge is the sampling edge and the other is the drive edge. A mode bit chooses which edge is which.

On the receive side, serial data is shifted into a slot register. The word is extracted at the last bit of each 32-bit half-frame, in one of five framings: standard I2S, left-justified, or right-justified with a 20-, 18- or 16-bit word. Shorter words are sign-extended. A left word is held until the right word that follows it completes, and the pair is then presented with a single-cycle strobe. On the transmit side, the word for the current channel is latched at the start of each half-frame and shifted out on the drive edge, in I2S or left-justified framing.

The frame is 64 bit clocks: 32 per channel.

Top module: `serial_audio_port`

## Requirements
- R1: A mode register is loaded from `cfg_wdata` when `cfg_we` is high. It uses bit 4 for edge polarity, bit 3 for output framing and bits 2:0 for the input framing code, and ignores bits 7:5. After reset it holds 0: I2S in, I2S out, rising-edge sampling.
- R2: With polarity 0, serial input is sampled on the rising bit-clock edge and `sdata_o` changes only after a falling edge. With polarity 1 the two edges swap roles.
- R3: Input code 0 (I2S): the word clock is low for the left channel. The 20-bit MSB is the bit sampled one bit clock after the word-clock transition. All other slot bits are ignored.
- R4: Input code 1 (left-justified): the word clock is high for the left channel. The MSB is sampled on the first sampling edge after the transition, and the remaining slot bits are ignored.
- R5: Input codes 2, 3 and 4 (right-justified, word clock high for left) take 20, 18 and 16 bits respectively. The LSB is on the 32nd sampling edge of the half-frame. Words of 18 and 16 bits are sign-extended to 20 bits, and earlier slot bits are ignored.
- R6: Input codes 5, 6 and 7 receive exactly as code 0.
- R7: `rx_valid` is high for one clock, shortly after the right word completes. It carries that right word in `rx_right` and the preceding left word in `rx_left`.
- R8: Output framing 0 (I2S): the MSB of the current channel's word is driven for the second slot bit, followed by the other 19 bits MSB first. The left channel is sent while the word clock is low.
- R9: Output framing 1 (left-justified): the MSB is driven for the first slot bit, and the left channel is sent while the word clock is high. In both output framings, every slot bit outside the word is 0.
- R10: The transmitted word is the value of `tx_left` or `tx_right` at the start of its half-frame. Later changes to these inputs affect only later half-frames.
- R11: After reset, `rx_valid` and `sdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode register write enable |
| cfg_wdata | input | 8 | Mode register write data |
| bclk_i | input | 1 | External bit clock |
| lrck_i | input | 1 | External word (channel) clock |
| sdata_i | input | 1 | Serial data in |
| sdata_o | output | 1 | Serial data out |
| tx_left | input | WORD_W | Left sample to transmit |
| tx_right | input | WORD_W | Right sample to transmit |
| rx_left | output | WORD_W | Received left sample |
| rx_right | output | WORD_W | Received right sample |
| rx_valid | output | 1 | One-cycle strobe for a received pair |

## Verification
A slot counter that is off by one shows up at once on the first received pair after it slips: the word is shifted by one bit, or the RJ sign extension is taken from the wrong bit. The same slip on the transmit side corrupts every bit of the next transmitted half-frame. A wrong channel-polarity decode swaps the two received words in the very next strobe, or sends the other channel's word. A polarity mix-up moves `sdata_o` transitions onto the sampling edge, and the bench, which samples just before that edge, then reads the previous bit.

// File: rtl/sap_pkg.sv
package sap_pkg;

  typedef enum logic [2:0] {
    IN_I2S      = 3'd0,
    IN_LJ       = 3'd1,
    IN_RJ_FULL  = 3'd2,
    IN_RJ_MID   = 3'd3,
    IN_RJ_SHORT = 3'd4
  } in_fmt_e;

  // codes above the last defined framing fall back to I2S
  function automatic in_fmt_e decode_in(input logic [2:0] code);
    in_fmt_e f;
    if (code > 3'd4) f = IN_I2S;
    else             f = in_fmt_e'(code);
    return f;
  endfunction

endpackage

// File: rtl/sap_edge_sync.sv
module sap_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic falling,
  input  logic bclk_i,
  input  logic lrck_i,
  input  logic sdin_i,
  output logic lrck_s,
  output logic sdin_s,
  output logic smp_pulse,
  output logic drv_pulse
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            bclk_d;
  logic            rise;
  logic            fall;

  assign raw = {sdin_i, lrck_i, bclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) bclk_d <= 1'b0;
    else     bclk_d <= synced[0];
  end

  assign rise      = synced[0] & ~bclk_d;
  assign fall      = ~synced[0] & bclk_d;
  assign smp_pulse = falling ? fall : rise;
  assign drv_pulse = falling ? rise : fall;
  assign lrck_s    = synced[1];
  assign sdin_s    = synced[2];

endmodule

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int SLOT_W = 32,
  parameter int CNT_W  = $clog2(SLOT_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_pulse,
  input  logic              lrck_s,
  input  logic              sdin_s,
  input  in_fmt_e           fmt,
  output logic [CNT_W-1:0]  slot_next,
  output logic              lr_last,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);
  localparam int MID_W   = WORD_W - 2;
  localparam int SHORT_W = WORD_W - 4;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SLOT_W - 1);
  localparam logic [CNT_W-1:0] IDLE_IDX = '1;

  logic [CNT_W-1:0]  slot_cnt;
  logic [SLOT_W-2:0] shreg;
  logic [SLOT_W-1:0] word;
  logic [WORD_W-1:0] ext;
  logic [WORD_W-1:0] left_hold;
  logic              left_ok;
  logic              is_left;

  // slot position of the bit arriving at the next sampling edge
  always_comb begin
    if (lrck_s != lr_last)        slot_next = '0;
    else if (slot_cnt == IDLE_IDX) slot_next = IDLE_IDX;
    else                          slot_next = slot_cnt + 1'b1;
  end

  assign word    = {shreg, sdin_s};
  assign is_left = (fmt == IN_I2S) ? ~lrck_s : lrck_s;

  always_comb begin
    case (fmt)
      IN_LJ:       ext = word[SLOT_W-1 -: WORD_W];
      IN_RJ_FULL:  ext = word[WORD_W-1:0];
      IN_RJ_MID:   ext = {{(WORD_W-MID_W){word[MID_W-1]}}, word[MID_W-1:0]};
      IN_RJ_SHORT: ext = {{(WORD_W-SHORT_W){word[SHORT_W-1]}}, word[SHORT_W-1:0]};
      default:     ext = word[SLOT_W-2 -: WORD_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_last   <= 1'b0;
      slot_cnt  <= IDLE_IDX;
      shreg     <= '0;
      left_hold <= '0;
      left_ok   <= 1'b0;
      rx_left   <= '0;
      rx_right  <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (smp_pulse) begin
        lr_last  <= lrck_s;
        slot_cnt <= slot_next;
        shreg    <= word[SLOT_W-2:0];
        if (slot_next == LAST_IDX) begin
          if (is_left) begin
            left_hold <= ext;
            left_ok   <= 1'b1;
          end else if (left_ok) begin
            rx_left  <= left_hold;
            rx_right <= ext;
            rx_valid <= 1'b1;
            left_ok  <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sap_tx.sv
module sap_tx #(
  parameter int WORD_W = 20,
  parameter int SLOT_W = 32,
  parameter int CNT_W  = $clog2(SLOT_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drv_pulse,
  input  logic              lrck_s,
  input  logic              out_lj,
  input  logic [CNT_W-1:0]  slot_next,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              sdata_o
);
  localparam logic [CNT_W-1:0] WLEN = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shadow;
  logic [WORD_W-1:0] fresh;
  logic [WORD_W-1:0] src;
  logic [WORD_W-1:0] shifted;
  logic              cur_left;
  logic              in_range;
  logic              first;
  logic              nxt_bit;

  assign first    = (slot_next == '0);
  assign cur_left = out_lj ? lrck_s : ~lrck_s;
  assign fresh    = cur_left ? tx_left : tx_right;
  assign src      = first ? fresh : shadow;

  always_comb begin
    if (out_lj) begin
      in_range = (slot_next < WLEN);
      shifted  = src << slot_next;
    end else begin
      in_range = !first && (slot_next <= WLEN);
      shifted  = src << (slot_next - 1'b1);
    end
    nxt_bit = in_range & shifted[WORD_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      sdata_o <= 1'b0;
    end else if (drv_pulse) begin
      sdata_o <= nxt_bit;
      if (first) shadow <= fresh;
    end
  end

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
  import sap_pkg::*;
#(
  parameter int WORD_W      = 20,
  parameter int SLOT_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              bclk_i,
  input  logic              lrck_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);
  localparam int CNT_W = $clog2(SLOT_W) + 1;

  logic [2:0]       in_code_q;
  logic             out_lj_q;
  logic             falling_q;
  logic             unused_rsvd;
  logic             lrck_s;
  logic             sdin_s;
  logic             smp_pulse;
  logic             drv_pulse;
  logic             lr_last;
  logic [CNT_W-1:0] slot_next;
  in_fmt_e          in_fmt;

  assign unused_rsvd = ^cfg_wdata[7:5];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_code_q <= 3'd0;
      out_lj_q  <= 1'b0;
      falling_q <= 1'b0;
    end else if (cfg_we) begin
      in_code_q <= cfg_wdata[2:0];
      out_lj_q  <= cfg_wdata[3];
      falling_q <= cfg_wdata[4];
    end
  end

  assign in_fmt = decode_in(in_code_q);

  sap_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .falling   (falling_q),
    .bclk_i    (bclk_i),
    .lrck_i    (lrck_i),
    .sdin_i    (sdata_i),
    .lrck_s    (lrck_s),
    .sdin_s    (sdin_s),
    .smp_pulse (smp_pulse),
    .drv_pulse (drv_pulse)
  );

  sap_rx #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .smp_pulse (smp_pulse),
    .lrck_s    (lrck_s),
    .sdin_s    (sdin_s),
    .fmt       (in_fmt),
    .slot_next (slot_next),
    .lr_last   (lr_last),
    .rx_left   (rx_left),
    .rx_right  (rx_right),
    .rx_valid  (rx_valid)
  );

  sap_tx #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .drv_pulse (drv_pulse),
    .lrck_s    (lrck_s),
    .out_lj    (out_lj_q),
    .slot_next (slot_next),
    .tx_left   (tx_left),
    .tx_right  (tx_right),
    .sdata_o   (sdata_o)
  );

endmodule

// File: rtl/sap_checker.sv
module sap_checker #(
  parameter int WORD_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [WORD_W-1:0] rx_right,
  input logic              sdata_o,
  input logic              smp_pulse,
  input logic              drv_pulse,
  input logic [2:0]        in_code_q,
  input logic              out_lj_q,
  input logic              falling_q
);
  logic [4:0] rj_top;
  assign rj_top = rx_right[WORD_W-1 -: 5];

  // R1
  mode_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_code_q == 3'd0 && !out_lj_q && !falling_q));

  // R2
  tx_on_drive_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata_o) |-> $past(drv_pulse));

  // R2
  edges_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({smp_pulse, drv_pulse}));

  // R7
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R7
  rx_strobe_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(smp_pulse));

  // R5
  rj_short_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && $past(in_code_q) == 3'd4) |-> ((&rj_top) || !(|rj_top)));

endmodule

bind serial_audio_port sap_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_valid  (rx_valid),
  .rx_right  (rx_right),
  .sdata_o   (sdata_o),
  .smp_pulse (smp_pulse),
  .drv_pulse (drv_pulse),
  .in_code_q (in_code_q),
  .out_lj_q  (out_lj_q),
  .falling_q (falling_q)
);

// File: tb/tb_serial_audio_port.sv
`timescale 1ns/1ps
module tb_serial_audio_port;
  localparam int W  = 20;
  localparam int HP = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [7:0]   cfg_wdata = 8'd0;
  logic         bclk_i = 1'b0;
  logic         lrck_i = 1'b0;
  logic         sdata_i = 1'b0;
  logic         sdata_o;
  logic [W-1:0] tx_left = '0;
  logic [W-1:0] tx_right = '0;
  logic [W-1:0] rx_left;
  logic [W-1:0] rx_right;
  logic         rx_valid;

  int checks = 0;
  int errs = 0;
  int strobes = 0;
  logic [W-1:0] got_l, got_r;
  bit finished = 0;

  int           cur_code = 0;
  logic         cur_lj = 1'b0;
  logic         cur_fall = 1'b0;

  always #2.5 clk = ~clk;

  serial_audio_port dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bclk_i(bclk_i), .lrck_i(lrck_i), .sdata_i(sdata_i), .sdata_o(sdata_o),
    .tx_left(tx_left), .tx_right(tx_right),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      strobes <= strobes + 1;
      got_l   <= rx_left;
      got_r   <= rx_right;
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int eff_code(input int code);
    return (code > 4) ? 0 : code;
  endfunction

  function automatic logic slot_bit(input int code, input logic [W-1:0] w, input int k, input int h);
    logic junk;
    junk = logic'((k + h) % 2);
    case (eff_code(code))
      1: return (k < 20) ? w[19-k] : junk;
      2: return (k >= 12) ? w[31-k] : junk;
      3: return (k >= 14) ? w[31-k] : junk;
      4: return (k >= 16) ? w[31-k] : junk;
      default: return (k >= 1 && k <= 20) ? w[20-k] : junk;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_rx(input int code, input logic [W-1:0] w);
    case (eff_code(code))
      3: return {{2{w[17]}}, w[17:0]};
      4: return {{4{w[15]}}, w[15:0]};
      default: return w;
    endcase
  endfunction

  function automatic logic exp_tx(input logic [W-1:0] w, input int k, input logic lj);
    if (lj) return (k < 20) ? w[19-k] : 1'b0;
    return (k >= 1 && k <= 20) ? w[20-k] : 1'b0;
  endfunction

  task automatic write_mode(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_code = int'(v[2:0]);
    cur_lj   = v[3];
    cur_fall = v[4];
  endtask

  task automatic run_frame(input bit checked, input logic [W-1:0] lw, input logic [W-1:0] rw);
    logic drv_lvl;
    logic lr;
    logic [W-1:0] snap;
    string rq;
    drv_lvl = cur_fall;
    for (int h = 0; h < 2; h++) begin
      lr = (eff_code(cur_code) == 0) ? logic'(h) : !logic'(h);
      for (int k = 0; k < 32; k++) begin
        @(negedge clk);
        bclk_i  = drv_lvl;
        lrck_i  = lr;
        sdata_i = slot_bit(cur_code, (h == 0) ? lw : rw, k, h);
        if (k == 0) snap = ((cur_lj ? lr : !lr) ? tx_left : tx_right);
        if (k == 16) begin   // R10 mid-half change must not leak
          tx_left  = tx_left ^ 20'h5A5A5;
          tx_right = tx_right ^ 20'hC3C3C;
        end
        repeat (HP - 1) @(negedge clk);
        if (checked) begin
          rq = cur_lj ? "R9 R10 R2" : "R8 R10 R2";
          check(rq, W'(sdata_o), W'(exp_tx(snap, k, cur_lj)));
        end
        @(negedge clk);
        bclk_i = !drv_lvl;
        repeat (HP - 1) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checked_frame(input logic [W-1:0] lw, input logic [W-1:0] rw);
    string rq;
    case (eff_code(cur_code))
      0: rq = (cur_code > 4) ? "R6" : "R3";
      1: rq = "R4";
      default: rq = "R5";
    endcase
    strobes = 0;
    run_frame(1'b1, lw, rw);
    check("R7 strobe count", W'(strobes), W'(1));
    check({rq, " left"}, got_l, exp_rx(cur_code, lw));
    check({rq, " right"}, got_r, exp_rx(cur_code, rw));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    int n;
    logic [W-1:0] lw, rw;
    n = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 rx_valid", W'(rx_valid), '0);
    check("R11 sdata_o", W'(sdata_o), '0);

    // R1 default mode: I2S both ways, rising-edge sampling
    tx_left = 20'h8_1234; tx_right = 20'h7_EDCB;
    run_frame(1'b0, 20'h1_1111, 20'h2_2222);
    checked_frame(20'hA_BCDE, 20'h5_4321);

    for (int pol = 0; pol < 2; pol++) begin
      for (int of = 0; of < 2; of++) begin
        for (int code = 0; code < 8; code++) begin
          // R1 reserved bits 7:5 set to check they are ignored
          write_mode({3'b101, logic'(pol), logic'(of), 3'(code)});
          tx_left  = W'(n * 32'd98011 + 32'd77);
          tx_right = W'(n * 32'd51437 + 32'd901);
          run_frame(1'b0, '0, '0);
          lw = W'(n * 32'd321731 + 32'd5);
          rw = W'(n * 32'd171293 + 32'd3);
          checked_frame(lw, rw);
          checked_frame(~lw, ~rw);
          n++;
        end
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

endmodule